// File: doc/BRIEF.md
# Reorder Buffer with Operand Wakeup

This block is the instruction window of a small out-of-order core that runs ALU operations only. A circular queue holds instructions in program order. Each slot also waits for the operands of its own instruction, so no separate scheduler is needed. A register rename table sits beside the queue. For each architectural register it records whether a result is still outstanding and, if so, which slot will produce it. It also holds the committed register value. That value is the register file, and register r resets to the value r.

One instruction can be dispatched per cycle. Each source operand is resolved in one of three ways:
- from the committed value, when no result is outstanding;
- from the result bus, when the producer executes in that same cycle;
- from the producer slot, when that slot already holds its result.

Otherwise the operand waits for its producer's slot number, called the tag, to appear on the bus. Each cycle in which the execution grant is high, the oldest slot that has both operands and has not yet executed is sent to the ALU. The result is broadcast on the bus together with that slot's tag. The head slot retires once its result is present. Retiring writes the result to the register file. If the head instruction raised an exception, the whole queue is discarded instead.

Occupancy is tracked by a three-state controller:
- EMPTY: nothing is held.
- PARTIAL: some slots are in use, and the queue is not full.
- FULL: every slot is in use.

Its transitions are:
- DISPATCH: EMPTY to PARTIAL.
- FILL: PARTIAL to FULL.
- RETIRE: FULL to PARTIAL.
- DRAIN: PARTIAL to EMPTY.
- FLUSH: any state to EMPTY.

Top module: `rob_core`

## Requirements
- R1: After reset the queue is empty. `disp_ready` is 1, and `bus_valid`, `cm_valid` and `flush_o` are 0.
- R2: A dispatch is accepted when `disp_valid` and `disp_ready` are both high. The new instruction goes into the slot given by `disp_tag`. `disp_tag` starts at 0, advances by one per accepted dispatch modulo DEPTH, and returns to 0 after a flush. `disp_ready` is low while DEPTH instructions are held.
- R3: A source register with no outstanding producer takes the committed value of that register. Register r holds the value r after reset.
- R4: A waiting source takes the bus value, and becomes ready, at the edge where the bus carries its producer's tag.
- R5: In the dispatch cycle, a source whose producer is on the bus takes the bus value. A source whose producer already holds its result takes that result.
- R6: When `ex_grant` is 1 and no flush occurs, the oldest held instruction whose two sources are ready and which has not executed is selected. The bus then shows its tag. With `ex_grant` at 0, nothing is selected.
- R7: The op codes are 0 add, 1 subtract, 2 bitwise AND and 3 bitwise OR. Code 3 raises an exception when its result is zero. Arithmetic wraps at DW bits.
- R8: When the oldest instruction has its result and no exception, `cm_valid` is 1 with its tag, destination and value. At the clock edge the value is written to the register file.
- R9: At retire, the rename entry of the destination is released only if it still names the retiring tag. Otherwise later readers keep waiting on the younger producer.
- R10: When the oldest instruction has its result and an exception, the following happens in that cycle: `flush_o` is 1, `cm_valid` is 0, the register file is not written, nothing is selected and dispatch is refused. After the edge the queue is empty and every rename entry is released.
- R11: The occupancy controller is in EMPTY exactly when nothing is held, and in FULL exactly when DEPTH instructions are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | 2 | Op code |
| disp_dst | input | 3 | Destination register |
| disp_src_a | input | 3 | First source register |
| disp_src_b | input | 3 | Second source register |
| ex_grant | input | 1 | The ALU may take an instruction this cycle |
| disp_ready | output | 1 | A dispatch would be accepted |
| disp_tag | output | 2 | Slot for the next dispatch |
| bus_valid | output | 1 | Result bus carries a result |
| bus_tag | output | 2 | Tag of the executing slot |
| bus_value | output | 8 | ALU result |
| cm_valid | output | 1 | Head instruction retires |
| cm_tag | output | 2 | Tag of the retiring slot |
| cm_dst | output | 3 | Destination being written |
| cm_value | output | 8 | Value being written |
| flush_o | output | 1 | Head exception discards the queue |

## Verification
The bench targets four hazards:
- A consumer dispatched in the very cycle its producer executes. A design without the bus bypass at dispatch would miss this wakeup and hang.
- A consumer dispatched while its producer is finished but not yet retired. A design that skipped this path would also wait forever, or read a stale register value.
- Two writes to one register with the older one retiring first. A design that released the rename entry unconditionally would hand a later reader the old committed value.
- An exception at the head with younger instructions behind it. A faulty flush would let those instructions retire, leave rename entries pointing at dead slots, or restart `disp_tag` at a nonzero slot.

Withheld grants fill the queue, which exposes wrong stall or oldest-first selection.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_ORX = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_e;
endpackage

// File: rtl/rob_alu.sv
module rob_alu
    import rob_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e           op,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] res,
    output logic          exc
);
    always_comb begin
        exc = 1'b0;
        res = '0;
        unique case (op)
            OP_ADD: res = opa + opb;
            OP_SUB: res = opa - opb;
            OP_AND: res = opa & opb;
            OP_ORX: begin
                res = opa | opb;
                exc = (res == '0);
            end
        endcase
    end
endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
    import rob_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int TAGW  = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            disp_req,
    input  logic            retire_go,
    input  logic            flush_go,
    output logic [TAGW-1:0] head,
    output logic [TAGW-1:0] tail,
    output logic            disp_ready,
    output logic            disp_fire
);
    occ_e          state_q, state_d;
    logic [CW-1:0] count_q, count_d;

    function automatic logic [TAGW-1:0] wrap_inc(input logic [TAGW-1:0] p);
        return (p == TAGW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign disp_ready = (state_q != OCC_FULL) && !flush_go;
    assign disp_fire  = disp_req && disp_ready;

    always_comb begin
        count_d = count_q;
        if (flush_go) begin
            count_d = '0;
        end else begin
            if (disp_fire) count_d = count_d + 1'b1;
            if (retire_go) count_d = count_d - 1'b1;
        end
    end

    // DISPATCH, FILL, RETIRE, DRAIN and FLUSH transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (disp_fire)
                    state_d = (count_d == CW'(DEPTH)) ? OCC_FULL : OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (flush_go || count_d == '0)  state_d = OCC_EMPTY;
                else if (count_d == CW'(DEPTH)) state_d = OCC_FULL;
            end
            OCC_FULL: begin
                if (flush_go || count_d == '0)  state_d = OCC_EMPTY;
                else if (count_d != CW'(DEPTH)) state_d = OCC_PARTIAL;
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush_go) begin
            head <= '0;
            tail <= '0;
        end else begin
            if (disp_fire) tail <= wrap_inc(tail);
            if (retire_go) head <= wrap_inc(head);
        end
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH)) else $error("occupancy above depth");
    a_r2_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_FULL) |-> !disp_fire) else $error("dispatch while full");
    a_r11_empty_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_EMPTY) == (count_q == '0)) else $error("empty state mismatch");
    a_r11_full_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_FULL) == (count_q == CW'(DEPTH))) else $error("full state mismatch");
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_go |=> (count_q == '0 && head == '0 && tail == '0)) else $error("flush left entries");
    a_r8_no_retire_empty: assert property (@(posedge clk) disable iff (!rst_n)
        retire_go |-> (state_q != OCC_EMPTY)) else $error("retire from empty queue");
endmodule

// File: rtl/rob_rename.sv
module rob_rename #(
    parameter  int NREG  = 8,
    parameter  int DW    = 8,
    parameter  int DEPTH = 4,
    localparam int REGW  = $clog2(NREG),
    localparam int TAGW  = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [REGW-1:0] rd_a,
    input  logic [REGW-1:0] rd_b,
    output logic            pend_a,
    output logic            pend_b,
    output logic [TAGW-1:0] tag_a,
    output logic [TAGW-1:0] tag_b,
    output logic [DW-1:0]   val_a,
    output logic [DW-1:0]   val_b,
    input  logic            wr_en,
    input  logic [REGW-1:0] wr_dst,
    input  logic [TAGW-1:0] wr_tag,
    input  logic            ret_en,
    input  logic [REGW-1:0] ret_dst,
    input  logic [TAGW-1:0] ret_tag,
    input  logic [DW-1:0]   ret_val,
    input  logic            flush
);
    logic            pend_q [NREG];
    logic [TAGW-1:0] tag_q  [NREG];
    logic [DW-1:0]   val_q  [NREG];

    assign pend_a = pend_q[rd_a];
    assign pend_b = pend_q[rd_b];
    assign tag_a  = tag_q[rd_a];
    assign tag_b  = tag_q[rd_b];
    assign val_a  = val_q[rd_a];
    assign val_b  = val_q[rd_b];

    always_ff @(posedge clk) begin
        for (int r = 0; r < NREG; r++) begin
            if (!rst_n) begin
                pend_q[r] <= 1'b0;
                tag_q[r]  <= '0;
                val_q[r]  <= DW'(r);
            end else begin
                if (flush) begin
                    pend_q[r] <= 1'b0;
                end else begin
                    if (ret_en && ret_dst == REGW'(r) && pend_q[r] && tag_q[r] == ret_tag)
                        pend_q[r] <= 1'b0;
                    if (wr_en && wr_dst == REGW'(r)) begin
                        pend_q[r] <= 1'b1;
                        tag_q[r]  <= wr_tag;
                    end
                end
                if (ret_en && ret_dst == REGW'(r))
                    val_q[r] <= ret_val;
            end
        end
    end

    a_r9_dst_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en |-> pend_q[ret_dst]) else $error("retiring register not marked pending");
endmodule

// File: rtl/rob_entries.sv
module rob_entries
    import rob_pkg::*;
#(
    parameter  int DEPTH = 4,
    parameter  int NREG  = 8,
    parameter  int DW    = 8,
    localparam int TAGW  = $clog2(DEPTH),
    localparam int REGW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            disp_en,
    input  logic [TAGW-1:0] disp_tag,
    input  op_e             disp_op,
    input  logic [REGW-1:0] disp_dst,
    input  logic            pend_a,
    input  logic [TAGW-1:0] tag_a,
    input  logic [DW-1:0]   val_a,
    input  logic            pend_b,
    input  logic [TAGW-1:0] tag_b,
    input  logic [DW-1:0]   val_b,
    input  logic [TAGW-1:0] head,
    input  logic            ex_grant,
    input  logic            flush,
    input  logic            ret_en,
    output logic            bus_valid,
    output logic [TAGW-1:0] bus_tag,
    output logic [DW-1:0]   bus_val,
    output logic            head_done,
    output logic            head_exc,
    output logic [REGW-1:0] head_dst,
    output logic [DW-1:0]   head_val
);
    typedef struct packed {
        logic            valid;
        logic            done;
        logic            exc;
        op_e             op;
        logic [REGW-1:0] dst;
        logic            ra;
        logic            rb;
        logic [TAGW-1:0] ta;
        logic [TAGW-1:0] tb;
        logic [DW-1:0]   va;
        logic [DW-1:0]   vb;
        logic [DW-1:0]   res;
    } ent_t;

    ent_t            ent_q [DEPTH];
    logic            sel_found;
    logic [TAGW-1:0] sel_idx;
    logic [DW-1:0]   alu_res;
    logic            alu_exc;
    logic            cap_ra, cap_rb;
    logic [DW-1:0]   cap_va, cap_vb;

    // oldest-first pick, scanning from the head
    always_comb begin
        logic [TAGW-1:0] idx;
        sel_found = 1'b0;
        sel_idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            idx = TAGW'((int'(head) + i) % DEPTH);
            if (!sel_found && ent_q[idx].valid && ent_q[idx].ra &&
                ent_q[idx].rb && !ent_q[idx].done) begin
                sel_found = 1'b1;
                sel_idx   = idx;
            end
        end
    end

    rob_alu #(.DW(DW)) u_alu (
        .op  (ent_q[sel_idx].op),
        .opa (ent_q[sel_idx].va),
        .opb (ent_q[sel_idx].vb),
        .res (alu_res),
        .exc (alu_exc)
    );

    assign bus_valid = sel_found && ex_grant && !flush;
    assign bus_tag   = sel_idx;
    assign bus_val   = alu_res;

    // operand capture at dispatch: committed value, bus bypass, finished producer
    always_comb begin
        cap_ra = 1'b1;
        cap_va = val_a;
        if (pend_a) begin
            if (bus_valid && bus_tag == tag_a)                       cap_va = bus_val;
            else if (ent_q[tag_a].valid && ent_q[tag_a].done)        cap_va = ent_q[tag_a].res;
            else begin
                cap_ra = 1'b0;
                cap_va = '0;
            end
        end
        cap_rb = 1'b1;
        cap_vb = val_b;
        if (pend_b) begin
            if (bus_valid && bus_tag == tag_b)                       cap_vb = bus_val;
            else if (ent_q[tag_b].valid && ent_q[tag_b].done)        cap_vb = ent_q[tag_b].res;
            else begin
                cap_rb = 1'b0;
                cap_vb = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else if (flush) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i].valid <= 1'b0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (bus_valid && ent_q[i].valid && !ent_q[i].ra && ent_q[i].ta == bus_tag) begin
                    ent_q[i].ra <= 1'b1;
                    ent_q[i].va <= bus_val;
                end
                if (bus_valid && ent_q[i].valid && !ent_q[i].rb && ent_q[i].tb == bus_tag) begin
                    ent_q[i].rb <= 1'b1;
                    ent_q[i].vb <= bus_val;
                end
                if (bus_valid && sel_idx == TAGW'(i)) begin
                    ent_q[i].done <= 1'b1;
                    ent_q[i].res  <= alu_res;
                    ent_q[i].exc  <= alu_exc;
                end
                if (ret_en && head == TAGW'(i))
                    ent_q[i].valid <= 1'b0;
            end
            if (disp_en)
                ent_q[disp_tag] <= '{valid: 1'b1, done: 1'b0, exc: 1'b0, op: disp_op,
                                     dst: disp_dst, ra: cap_ra, rb: cap_rb, ta: tag_a,
                                     tb: tag_b, va: cap_va, vb: cap_vb, res: '0};
        end
    end

    assign head_done = ent_q[head].valid && ent_q[head].done;
    assign head_exc  = ent_q[head].exc;
    assign head_dst  = ent_q[head].dst;
    assign head_val  = ent_q[head].res;

    a_r4_done_had_operands: assert property (@(posedge clk) disable iff (!rst_n)
        head_done |-> (ent_q[head].ra && ent_q[head].rb)) else $error("finished without operands");
    a_r6_grant_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_grant |-> !bus_valid) else $error("issue without grant");
    a_r6_issue_once: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> ent_q[$past(bus_tag)].done || $past(flush)) else $error("issued slot not marked done");
endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter  int DEPTH = 4,
    parameter  int NREG  = 8,
    parameter  int DW    = 8,
    localparam int TAGW  = $clog2(DEPTH),
    localparam int REGW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            disp_valid,
    input  logic [1:0]      disp_op,
    input  logic [REGW-1:0] disp_dst,
    input  logic [REGW-1:0] disp_src_a,
    input  logic [REGW-1:0] disp_src_b,
    input  logic            ex_grant,
    output logic            disp_ready,
    output logic [TAGW-1:0] disp_tag,
    output logic            bus_valid,
    output logic [TAGW-1:0] bus_tag,
    output logic [DW-1:0]   bus_value,
    output logic            cm_valid,
    output logic [TAGW-1:0] cm_tag,
    output logic [REGW-1:0] cm_dst,
    output logic [DW-1:0]   cm_value,
    output logic            flush_o
);
    logic [TAGW-1:0] head, tail;
    logic            disp_fire, head_done, head_exc;
    logic            retire_go, flush_go;
    logic [REGW-1:0] head_dst;
    logic [DW-1:0]   head_val;
    logic            pend_a, pend_b;
    logic [TAGW-1:0] tag_a, tag_b;
    logic [DW-1:0]   val_a, val_b;

    assign retire_go = head_done && !head_exc;
    assign flush_go  = head_done && head_exc;

    rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .disp_req(disp_valid), .retire_go(retire_go),
        .flush_go(flush_go), .head(head), .tail(tail), .disp_ready(disp_ready),
        .disp_fire(disp_fire)
    );

    rob_rename #(.NREG(NREG), .DW(DW), .DEPTH(DEPTH)) u_rename (
        .clk(clk), .rst_n(rst_n), .rd_a(disp_src_a), .rd_b(disp_src_b),
        .pend_a(pend_a), .pend_b(pend_b), .tag_a(tag_a), .tag_b(tag_b),
        .val_a(val_a), .val_b(val_b), .wr_en(disp_fire), .wr_dst(disp_dst),
        .wr_tag(tail), .ret_en(retire_go), .ret_dst(head_dst), .ret_tag(head),
        .ret_val(head_val), .flush(flush_go)
    );

    rob_entries #(.DEPTH(DEPTH), .NREG(NREG), .DW(DW)) u_entries (
        .clk(clk), .rst_n(rst_n), .disp_en(disp_fire), .disp_tag(tail),
        .disp_op(op_e'(disp_op)), .disp_dst(disp_dst),
        .pend_a(pend_a), .tag_a(tag_a), .val_a(val_a),
        .pend_b(pend_b), .tag_b(tag_b), .val_b(val_b),
        .head(head), .ex_grant(ex_grant), .flush(flush_go), .ret_en(retire_go),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_value),
        .head_done(head_done), .head_exc(head_exc), .head_dst(head_dst),
        .head_val(head_val)
    );

    assign disp_tag = tail;
    assign cm_valid = retire_go;
    assign cm_tag   = head;
    assign cm_dst   = head_dst;
    assign cm_value = head_val;
    assign flush_o  = flush_go;
endmodule

// File: tb/rob_core_tb.sv
`timescale 1ns/1ps
module rob_core_tb;
    localparam int DEPTH = 4;
    localparam int NREG  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disp_valid = 1'b0;
    logic [1:0] disp_op = '0;
    logic [2:0] disp_dst = '0, disp_src_a = '0, disp_src_b = '0;
    logic       ex_grant = 1'b0;
    logic       disp_ready, bus_valid, cm_valid, flush_o;
    logic [1:0] disp_tag, bus_tag, cm_tag;
    logic [7:0] bus_value, cm_value;
    logic [2:0] cm_dst;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rob_core u_dut (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_dst(disp_dst), .disp_src_a(disp_src_a), .disp_src_b(disp_src_b),
        .ex_grant(ex_grant), .disp_ready(disp_ready), .disp_tag(disp_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
        .cm_valid(cm_valid), .cm_tag(cm_tag), .cm_dst(cm_dst), .cm_value(cm_value),
        .flush_o(flush_o)
    );

    typedef struct {
        int tag; int op; int dst;
        bit ra; bit rb; int ta; int tb; int va; int vb;
        bit done; int res; bit exc;
    } m_t;

    m_t q[$];
    bit mp[NREG];
    int mt[NREG];
    int mr[NREG];
    int mtail;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void m_alu(input int op, input int a, input int b,
                                  output int r, output bit e);
        e = 1'b0;
        case (op)
            0: r = (a + b) & 255;
            1: r = (a - b) & 255;
            2: r = a & b;
            default: begin r = a | b; e = (r == 0); end
        endcase
    endfunction

    function automatic void m_reset();
        q.delete();
        for (int r = 0; r < NREG; r++) begin mp[r] = 0; mt[r] = 0; mr[r] = r; end
        mtail = 0;
    endfunction

    // capture one source at dispatch from the model state before the edge
    function automatic void m_cap(input int s, input bit bv, input int btag, input int bval,
                                  output bit rdy, output int tg, output int v);
        rdy = 1'b1; tg = mt[s]; v = mr[s];
        if (mp[s]) begin
            if (bv && btag == mt[s]) v = bval;
            else begin
                rdy = 1'b0; v = 0;
                foreach (q[k]) if (q[k].tag == mt[s] && q[k].done) begin rdy = 1'b1; v = q[k].res; end
            end
        end
    endfunction

    task automatic step(input bit v, input int op, input int d, input int sa,
                        input int sb, input bit g);
        bit hd, e_fl, e_cm, e_rdy, e_bus, x, fire;
        int pk, res;
        m_t n;
        @(negedge clk);
        disp_valid = v; disp_op = 2'(op); disp_dst = 3'(d);
        disp_src_a = 3'(sa); disp_src_b = 3'(sb); ex_grant = g;
        #1;
        hd    = (q.size() > 0) && q[0].done;
        e_fl  = hd && q[0].exc;
        e_cm  = hd && !q[0].exc;
        e_rdy = (q.size() < DEPTH) && !e_fl;
        e_bus = 1'b0; pk = 0; res = 0; x = 1'b0;
        if (g && !e_fl)
            for (int k = 0; k < q.size(); k++)
                if (!e_bus && q[k].ra && q[k].rb && !q[k].done) begin e_bus = 1'b1; pk = k; end
        if (e_bus) m_alu(q[pk].op, q[pk].va, q[pk].vb, res, x);
        chk("R2", "disp_ready", int'(disp_ready), int'(e_rdy));
        chk("R2", "disp_tag", int'(disp_tag), mtail);
        chk("R6", "bus_valid", int'(bus_valid), int'(e_bus));
        if (e_bus) begin
            chk("R6", "bus_tag", int'(bus_tag), q[pk].tag);
            chk("R7 R3 R4 R5", "bus_value", int'(bus_value), res);
        end
        chk("R8", "cm_valid", int'(cm_valid), int'(e_cm));
        chk("R10", "flush_o", int'(flush_o), int'(e_fl));
        if (e_cm) begin
            chk("R8", "cm_tag", int'(cm_tag), q[0].tag);
            chk("R8", "cm_dst", int'(cm_dst), q[0].dst);
            chk("R8 R9", "cm_value", int'(cm_value), q[0].res);
        end
        // model the clock edge
        fire = v && e_rdy;
        if (fire) begin
            n.tag = mtail; n.op = op; n.dst = d; n.done = 0; n.res = 0; n.exc = 0;
            m_cap(sa, e_bus, e_bus ? q[pk].tag : -1, res, n.ra, n.ta, n.va);
            m_cap(sb, e_bus, e_bus ? q[pk].tag : -1, res, n.rb, n.tb, n.vb);
        end
        if (e_fl) begin
            q.delete();
            for (int r = 0; r < NREG; r++) mp[r] = 0;
            mtail = 0;
        end else begin
            if (e_bus) begin
                int bt = q[pk].tag;
                q[pk].done = 1; q[pk].res = res; q[pk].exc = x;
                foreach (q[k]) begin
                    if (!q[k].ra && q[k].ta == bt) begin q[k].ra = 1; q[k].va = res; end
                    if (!q[k].rb && q[k].tb == bt) begin q[k].rb = 1; q[k].vb = res; end
                end
            end
            if (e_cm) begin
                mr[q[0].dst] = q[0].res;
                if (mp[q[0].dst] && mt[q[0].dst] == q[0].tag) mp[q[0].dst] = 0;
                void'(q.pop_front());
            end
            if (fire) begin
                q.push_back(n);
                mp[d] = 1; mt[d] = mtail;
                mtail = (mtail + 1) % DEPTH;
            end
        end
    endtask

    task automatic idle(input int n, input bit g);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, g);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        m_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "disp_ready", int'(disp_ready), 1);
        chk("R1", "bus_valid", int'(bus_valid), 0);
        chk("R1", "cm_valid", int'(cm_valid), 0);
        chk("R1", "flush_o", int'(flush_o), 0);
        chk("R1", "disp_tag", int'(disp_tag), 0);

        // R3 R7 independent ops from committed values
        step(1, 0, 1, 2, 3, 1);
        step(1, 1, 4, 5, 2, 1);
        step(1, 2, 6, 7, 3, 1);
        step(1, 3, 0, 6, 5, 1);
        idle(4, 1);

        // R4 dependency chain on one register
        for (int i = 0; i < 4; i++) step(1, 0, 1, 1, 1, 1);
        idle(6, 1);

        // R2 fill with grant withheld, then drain
        for (int i = 0; i < 6; i++) step(1, 1, 2 + (i % 3), 3, 4, 0);
        idle(10, 1);

        // R5 bus bypass at dispatch, then finished-producer path
        step(1, 0, 2, 3, 4, 0);
        step(1, 0, 5, 2, 2, 1);
        step(1, 1, 6, 2, 5, 0);
        idle(6, 1);

        // R9 two writes to r3; older retires while younger is still waiting
        step(1, 0, 3, 1, 1, 0);
        step(1, 0, 3, 3, 3, 0);
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        step(1, 0, 7, 3, 0, 0);
        idle(8, 1);

        // R10 exception at head with younger work behind it
        step(1, 1, 7, 2, 2, 1);
        step(1, 3, 6, 7, 7, 0);
        step(1, 0, 1, 6, 2, 0);
        step(1, 0, 2, 1, 1, 0);
        idle(2, 1);
        step(1, 3, 5, 7, 7, 1);
        idle(4, 1);
        step(1, 0, 4, 6, 1, 1);
        idle(5, 1);

        // mixed traffic
        for (int i = 0; i < 3000; i++)
            step(bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 7)), bit'($urandom_range(0, 9) < 7));
        idle(12, 1);
        summary();
    end
endmodule